// File: doc/BRIEF.md
# Windowed 2D Convolution Multiply-Accumulate Engine

This block forms the weighted sum of a rectangular pixel window against a stored table of signed 8-bit weights. A line-delay block outside it supplies one pixel per image row for the current column, and the engine keeps its own horizontal history of the last eight columns. It runs on a fast clock. A pixel strobe marks each pixel period. A bank of 16 multipliers is shared over one, two or four fast cycles per pixel, so the window can be 4x4, 8 rows by 4 columns, or 8x8. The pixel rate falls as the window grows.

Each window sum is kept at 32-bit signed precision. An optional expansion adder adds a partial sum that arrives from a neighbouring engine. That partial sum can be taken straight away or four pixels late, which lets several engines share one larger window. A gain stage then keeps a 20-bit field of the 32-bit total and raises an overflow flag when the dropped upper bits carry magnitude. The weights are written through an address/data port into a shadow table, and that table is copied into use only on a frame strobe.

Top module: `conv_window_mac`

## Requirements
- R1: The weight table holds 64 signed 8-bit entries. The weight for window row r and column c sits at address r*8+c.
- R2: mode_i selects the window and the cycles per pixel. 0 gives 4x4 in 1 cycle, 1 gives 8 rows x 4 columns in 2 cycles, and 2 or 3 gives 8x8 in 4 cycles. Row r of the window is bits [8r+7:8r] of taps_i. Column 0 is the newest pixel and column c is the pixel strobed c periods earlier.
- R3: The window sum is the exact 32-bit signed sum of unsigned pixel times signed weight over the active window.
- R4: With exp_en_i low, exp_i has no effect on the result.
- R5: With exp_en_i high, the value added is exp_i from the same strobe when exp_dly_i is low. When exp_dly_i is high, it is exp_i from four strobes earlier. The delay line advances on every strobe and is zero after reset.
- R6: gain_i = g selects the output field: res_o takes bits [31-4g : 12-4g] of the 32-bit total.
- R7: ovf_o is set when the bits above the kept field are not all equal to the field's top bit. It is never set for g = 0.
- R8: vld_o pulses for one cycle, N+1 clock edges after the strobe edge, where N is the cycles per pixel. res_o and ovf_o hold their values between pulses.
- R9: Weight writes take effect only at the next frame_i strobe.
- R10: While rst_ni is low, res_o, ovf_o and vld_o are zero, and the weights and pixel history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast MAC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel strobe, one cycle every N cycles |
| taps_i | input | 64 | Column pixels, 8 rows of 8 bits |
| frame_i | input | 1 | Frame boundary, copies the shadow weights into use |
| coef_we_i | input | 1 | Weight write enable |
| coef_addr_i | input | 6 | Weight address |
| coef_data_i | input | 8 | Signed weight value |
| exp_i | input | 32 | Partial sum from the previous engine |
| mode_i | input | 2 | Window and cycles-per-pixel select |
| exp_en_i | input | 1 | Expansion adder enable |
| exp_dly_i | input | 1 | Delay the expansion input by four pixels |
| gain_i | input | 2 | Output field select |
| res_o | output | 20 | Aligned result field |
| ovf_o | output | 1 | Field overflow |
| vld_o | output | 1 | Result valid pulse |

## Verification
Each pixel's result becomes due N+1 clock edges after the edge that takes its strobe: 2, 3 or 5 edges in the three modes. When the bench drives a strobe, it records the cycle count the result is due at together with the expected field and flag. A monitor on the falling edge pops that entry when vld_o rises and compares the value and the arrival cycle. A pulse that comes early or late, or one with nothing outstanding, is reported. The hold checks read res_o over several idle cycles after the last pulse.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 8;
  localparam int ROWS      = 8;
  localparam int COLS      = 8;
  localparam int MACS      = 16;
  localparam int ACC_W     = 32;
  localparam int OUT_W     = 20;
  localparam int EXP_DLY   = 4;
  localparam int GAIN_STEP = 4;
  localparam int PH_W      = 2;

  typedef enum logic [1:0] {
    MODE_X1     = 2'd0,
    MODE_X2     = 2'd1,
    MODE_X4     = 2'd2,
    MODE_X4_ALT = 2'd3
  } mac_mode_e;
endpackage

// File: rtl/conv_coef_store.sv
module conv_coef_store
  import conv_pkg::*;
#(
  parameter int TAPS = ROWS * COLS,
  parameter int CW   = COEF_W,
  localparam int AW  = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [CW-1:0]            data_i,
  input  logic                     frame_i,
  output logic [TAPS-1:0][CW-1:0]  coef_o
);
  logic [TAPS-1:0][CW-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i) shadow_q[addr_i] <= data_i;
      if (frame_i) active_q <= shadow_q;
    end
  end

  assign coef_o = active_q;

  p_hold_until_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(active_q));
  p_frame_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> active_q == $past(shadow_q));
endmodule

// File: rtl/conv_exp_path.sv
module conv_exp_path
  import conv_pkg::*;
#(
  parameter int W   = ACC_W,
  parameter int DLY = EXP_DLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pix_en_i,
  input  logic [W-1:0] exp_i,
  input  logic         en_i,
  input  logic         dly_i,
  output logic [W-1:0] term_o
);
  logic [DLY-1:0][W-1:0] pipe_q;
  logic [W-1:0]          term_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      term_q <= '0;
    end else if (pix_en_i) begin
      pipe_q[0] <= exp_i;
      for (int i = 1; i < DLY; i++) pipe_q[i] <= pipe_q[i-1];
      if (!en_i)     term_q <= '0;
      else if (dly_i) term_q <= pipe_q[DLY-1];
      else           term_q <= exp_i;
    end
  end

  assign term_o = term_q;

  p_exp_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && !en_i) |=> term_o == '0);
  p_term_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(term_o));
endmodule

// File: rtl/conv_mac_array.sv
module conv_mac_array
  import conv_pkg::*;
#(
  parameter int PW  = PIX_W,
  parameter int CW  = COEF_W,
  parameter int NR  = ROWS,
  parameter int NC  = COLS,
  parameter int NM  = MACS,
  parameter int AW  = ACC_W,
  localparam int TAPS = NR * NC,
  localparam int RW   = $clog2(NR),
  localparam int CLW  = $clog2(NC),
  localparam int HC   = NC / 2,
  localparam int R2   = NM / HC,
  localparam int R4   = NM / NC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pix_en_i,
  input  logic [NR*PW-1:0]         taps_i,
  input  logic [1:0]               mode_i,
  input  logic [TAPS-1:0][CW-1:0]  coef_i,
  input  logic [AW-1:0]            term_i,
  output logic [AW-1:0]            sum_o,
  output logic                     done_o
);
  logic [NR-1:0][NC-1:0][PW-1:0] win_q;
  logic [PH_W-1:0]               phase_q;
  logic                          active_q, done_q, last_ph;
  logic signed [AW-1:0]          acc_q, sum_q, partial, total;
  logic signed [AW-1:0]          prod [NM];

  always_comb begin
    case (mode_i)
      MODE_X1: last_ph = 1'b1;
      MODE_X2: last_ph = phase_q[0];
      default: last_ph = &phase_q;
    endcase
  end

  for (genvar k = 0; k < NM; k++) begin : g_lane
    logic [RW-1:0]  rsel;
    logic [CLW-1:0] csel;
    logic [PW-1:0]  pix;
    logic [CW-1:0]  cf;
    always_comb begin
      int r, c;
      case (mode_i)
        MODE_X1: begin r = k / HC; c = k % HC; end
        MODE_X2: begin r = int'(phase_q) * R2 + k / HC; c = k % HC; end
        default: begin r = int'(phase_q) * R4 + k / NC; c = k % NC; end
      endcase
      rsel = RW'(r);
      csel = CLW'(c);
    end
    assign pix = win_q[rsel][csel];
    assign cf  = coef_i[{rsel, csel}];
    assign prod[k] = AW'($signed({1'b0, pix})) * AW'($signed(cf));
  end

  always_comb begin
    partial = '0;
    for (int k = 0; k < NM; k++) partial = partial + prod[k];
  end

  assign total = ((phase_q == '0) ? '0 : acc_q) + partial + (last_ph ? $signed(term_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      phase_q  <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      acc_q    <= '0;
      sum_q    <= '0;
    end else begin
      done_q <= active_q && last_ph;
      if (active_q && last_ph) sum_q <= total;
      else if (active_q)       acc_q <= total;
      if (pix_en_i) begin
        active_q <= 1'b1;
        phase_q  <= '0;
        for (int r = 0; r < NR; r++) begin
          win_q[r][0] <= taps_i[r*PW +: PW];
          for (int c = 1; c < NC; c++) win_q[r][c] <= win_q[r][c-1];
        end
      end else if (active_q) begin
        if (last_ph) active_q <= 1'b0;
        else         phase_q  <= phase_q + 1'b1;
      end
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;

  p_x1_single_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_i == MODE_X1) |-> phase_q == '0);
  p_done_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_i != MODE_X1) |=> !done_o);
endmodule

// File: rtl/conv_gain.sv
module conv_gain
  import conv_pkg::*;
#(
  parameter int AW   = ACC_W,
  parameter int OW   = OUT_W,
  parameter int STEP = GAIN_STEP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [AW-1:0] sum_i,
  input  logic [1:0]    gain_i,
  output logic [OW-1:0] res_o,
  output logic          ovf_o,
  output logic          vld_o
);
  logic signed [AW-1:0] s, hi;
  logic [OW-1:0]        fld;
  logic                 ovf;
  logic [OW-1:0]        res_q;
  logic                 ovf_q, vld_q;

  always_comb begin
    int sh;
    sh  = STEP * (3 - int'(gain_i));
    s   = $signed(sum_i);
    fld = OW'(s >>> sh);
    hi  = s >>> (sh + OW - 1);
    ovf = (hi != '0) && (hi != '1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= done_i;
      if (done_i) begin
        res_q <= fld;
        ovf_q <= ovf;
      end
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;
  assign vld_o = vld_q;

  p_no_ovf_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && gain_i == 2'd0) |=> !ovf_o);
  p_vld_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> vld_o);
  p_res_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(res_o) && $stable(ovf_o) && !vld_o));
endmodule

// File: rtl/conv_window_mac.sv
module conv_window_mac
  import conv_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pix_en_i,
  input  logic [ROWS*PIX_W-1:0] taps_i,
  input  logic                  frame_i,
  input  logic                  coef_we_i,
  input  logic [5:0]            coef_addr_i,
  input  logic [COEF_W-1:0]     coef_data_i,
  input  logic [ACC_W-1:0]      exp_i,
  input  logic [1:0]            mode_i,
  input  logic                  exp_en_i,
  input  logic                  exp_dly_i,
  input  logic [1:0]            gain_i,
  output logic [OUT_W-1:0]      res_o,
  output logic                  ovf_o,
  output logic                  vld_o
);
  localparam int TAPS = ROWS * COLS;

  logic [TAPS-1:0][COEF_W-1:0] coef;
  logic [ACC_W-1:0]            term, sum;
  logic                        done;

  conv_coef_store #(.TAPS(TAPS), .CW(COEF_W)) u_coef (
    .clk_i, .rst_ni, .we_i(coef_we_i), .addr_i(coef_addr_i),
    .data_i(coef_data_i), .frame_i, .coef_o(coef)
  );

  conv_exp_path #(.W(ACC_W), .DLY(EXP_DLY)) u_exp (
    .clk_i, .rst_ni, .pix_en_i, .exp_i, .en_i(exp_en_i),
    .dly_i(exp_dly_i), .term_o(term)
  );

  conv_mac_array u_mac (
    .clk_i, .rst_ni, .pix_en_i, .taps_i, .mode_i, .coef_i(coef),
    .term_i(term), .sum_o(sum), .done_o(done)
  );

  conv_gain u_gain (
    .clk_i, .rst_ni, .done_i(done), .sum_i(sum), .gain_i,
    .res_o, .ovf_o, .vld_o
  );
endmodule

// File: tb/conv_window_mac_test.sv
module conv_window_mac_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pix_en = 0, frame = 0, coef_we = 0, exp_en = 0, exp_dly = 0;
  logic [63:0] taps = '0;
  logic [5:0]  coef_addr = '0;
  logic [7:0]  coef_data = '0;
  logic [31:0] exp_v = '0;
  logic [1:0]  mode = '0, gain = '0;
  logic [19:0] res;
  logic        ovf, vld;

  always #2 clk = ~clk;

  conv_window_mac uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .taps_i(taps), .frame_i(frame),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .exp_i(exp_v), .mode_i(mode), .exp_en_i(exp_en), .exp_dly_i(exp_dly),
    .gain_i(gain), .res_o(res), .ovf_o(ovf), .vld_o(vld)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit fin = 0;

  // mode, gain, exp_en, exp_dly, coef seed, pixel seed, exp scale
  localparam int NCASE = 6;
  localparam int C_MODE [NCASE] = '{0, 1, 2, 2, 0, 3};
  localparam int C_GAIN [NCASE] = '{0, 1, 2, 3, 3, 1};
  localparam int C_EN   [NCASE] = '{0, 0, 1, 1, 1, 0};
  localparam int C_DLY  [NCASE] = '{0, 0, 0, 1, 1, 0};
  localparam int C_CS   [NCASE] = '{3, 5, 7, 11, 13, 17};
  localparam int C_PS   [NCASE] = '{1, 2, 3, 4, 5, 6};
  localparam int C_SC   [NCASE] = '{1, 1, 8192, 1, 64, 1};

  int wm [8][8];
  int cs [64];
  int ca [64];
  int hist [256];
  int npix = 0;

  int    q_res [256];
  int    q_ovf [256];
  int    q_due [256];
  string q_tag [256];
  int    qh = 0, qt = 0;

  function automatic string case_tag(int i);
    case (i)
      0: return "R1 R2 R3 R4 R6 4x4";
      1: return "R2 R4 R6 8x4";
      2: return "R2 R5 R6 R7 8x8 expansion";
      3: return "R5 R6 R7 8x8 delayed expansion";
      4: return "R2 R5 R7 4x4 delayed";
      default: return "R2 R3 R6 alt 8x8";
    endcase
  endfunction

  function automatic int cval(int a, int s);
    return ((a * s * 29 + s * 7 + a * 3) % 255) - 127;
  endfunction

  function automatic int pval(int i, int r, int s);
    return (i * 31 + r * 57 + s * 13 + i * r * 5) % 256;
  endfunction

  function automatic int eval(int i, int s, int sc);
    return (((i * 7919 + s * 131) % 4096) - 2048) * sc;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (qh == qt) chk(0, "R8 valid with nothing outstanding", 1, 0);
      else begin
        chk(int'(res) == q_res[qh], {q_tag[qh], " result"}, res, q_res[qh]);
        chk(int'(ovf) == q_ovf[qh], {q_tag[qh], " R7 overflow"}, ovf, q_ovf[qh]);
        chk(cyc == q_due[qh], {q_tag[qh], " R8 latency"}, cyc, q_due[qh]);
        qh++;
      end
    end
  end

  task automatic load_coefs(int s);
    for (int a = 0; a < 64; a++) begin
      coef_we = 1; coef_addr = 6'(a); coef_data = 8'(cval(a, s));
      cs[a] = cval(a, s);
      @(negedge clk);
    end
    coef_we = 0;
  endtask

  task automatic do_frame();
    frame = 1;
    @(negedge clk);
    frame = 0;
    for (int a = 0; a < 64; a++) ca[a] = cs[a];
  endtask

  task automatic do_pix(int ps, int ev, string tag);
    int n, nr, ncl, s, term, tot, sh, hi, fld;
    n   = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : 4;
    nr  = (mode == 2'd0) ? 4 : 8;
    ncl = (mode == 2'd2 || mode == 2'd3) ? 8 : 4;
    for (int r = 0; r < 8; r++) begin
      for (int c = 7; c > 0; c--) wm[r][c] = wm[r][c-1];
      wm[r][0] = pval(npix, r, ps);
      taps[r*8 +: 8] = 8'(wm[r][0]);
    end
    s = 0;
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < ncl; c++) s += wm[r][c] * ca[r*8 + c];
    if (!exp_en) term = 0;
    else if (exp_dly) term = (npix >= 4) ? hist[npix-4] : 0;
    else term = ev;
    hist[npix] = ev;
    npix++;
    tot = s + term;
    sh  = 4 * (3 - int'(gain));
    fld = (tot >>> sh) & 32'h000F_FFFF;
    hi  = tot >>> (sh + 19);
    q_res[qt] = fld;
    q_ovf[qt] = (hi != 0 && hi != -1) ? 1 : 0;
    q_due[qt] = cyc + n + 2;
    q_tag[qt] = tag;
    qt++;
    exp_v  = 32'(ev);
    pix_en = 1;
    @(negedge clk);
    pix_en = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) wm[r][c] = 0;
    for (int a = 0; a < 64; a++) begin cs[a] = 0; ca[a] = 0; end
    npix = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R8 watchdog expired act=%0d exp=%0d", qt - qh, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [19:0] held;
    model_reset();
    repeat (3) @(negedge clk);
    chk(res == '0, "R10 reset res_o", res, 0);
    chk(ovf == 1'b0, "R10 reset ovf_o", ovf, 0);
    chk(vld == 1'b0, "R10 reset vld_o", vld, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NCASE; i++) begin
      mode = 2'(C_MODE[i]); gain = 2'(C_GAIN[i]);
      exp_en = C_EN[i][0]; exp_dly = C_DLY[i][0];
      load_coefs(C_CS[i]);
      do_frame();
      for (int p = 0; p < 8; p++) do_pix(C_PS[i], eval(npix, C_PS[i], C_SC[i]), case_tag(i));
      repeat (8) @(negedge clk);
    end

    // R8: result holds while idle
    held = res;
    repeat (5) @(negedge clk);
    chk(res == held, "R8 hold while idle", res, held);
    chk(vld == 1'b0, "R8 no pulse while idle", vld, 0);

    // R9: shadow writes stay hidden until the frame strobe
    mode = 2'd2; gain = 2'd0; exp_en = 0; exp_dly = 0;
    load_coefs(99);
    do_pix(8, 1234, "R9 before frame");
    repeat (6) @(negedge clk);
    do_frame();
    do_pix(8, 1234, "R9 after frame");
    repeat (6) @(negedge clk);

    // R10 and R5: reset clears history and delay line
    rst_n = 0;
    model_reset();
    @(negedge clk);
    chk(res == '0, "R10 reset mid-run res_o", res, 0);
    chk(vld == 1'b0, "R10 reset mid-run vld_o", vld, 0);
    rst_n = 1;
    @(negedge clk);
    mode = 2'd2; gain = 2'd3; exp_en = 1; exp_dly = 1;
    load_coefs(21);
    do_frame();
    for (int p = 0; p < 6; p++) do_pix(9, 1000 + 111 * p, "R5 R10 delay after reset");
    repeat (8) @(negedge clk);
    chk(qh == qt, "R8 all results delivered", qt - qh, 0);

    fin = 1;
    summary();
    $finish;
  end
endmodule